// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip request port and an external 128K x 8 asynchronous static RAM. A client offers one access at a time on a valid/ready port: a write with its address and byte, or a read with its address. The sequencer turns each request into a strobe sequence on the memory pins. The pins are a 17-bit address, an active-low chip enable, an active-high chip enable, an active-low write strobe and an active-low output enable. The shared 8-bit data bus is split into an outgoing byte, an incoming byte and a drive-enable for the pad.

Every analogue timing limit of the memory is met by counting whole system clock cycles. The counts are derived at elaboration time from the clock period and the nanosecond limits, which are given as parameters. Writes are terminated by the write strobe. Reads hold the output enable low long enough to cover both the address access time and the output-enable access time. A read returns its byte on a registered output together with a one-cycle valid pulse. After every read, the bus is left undriven for a turnaround gap before any write may drive it.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, req_ready is 1, mem_ce_n is 1, mem_ce is 0, mem_we_n is 1, mem_oe_n is 1, mem_dq_oe is 0 and rvalid is 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. From the next cycle, req_ready stays 0 until the access ends. A req_valid raised while req_ready is 0 has no effect on the memory.
- R3: During a write, mem_we_n is low for exactly ceil(T_WP_NS/CLK_PERIOD_NS) consecutive cycles (3 at defaults). Throughout that time mem_ce_n is 0, mem_ce is 1 and mem_oe_n is 1.
- R4: For a write, mem_dq_oe is 1 in the cycle before mem_we_n falls and in the cycle after it rises. mem_dq_out holds the request byte, unchanged, over that whole span.
- R5: mem_addr never changes between two consecutive cycles in which mem_ce_n is 0. A new address appears only together with a fresh chip-enable assertion, while mem_we_n is 1.
- R6: During a read, mem_we_n stays 1 and mem_oe_n falls one cycle after mem_ce_n falls. mem_oe_n then stays low for exactly ceil(T_AA_NS/CLK_PERIOD_NS)+2 cycles (5 at defaults).
- R7: Each read produces exactly one single-cycle rvalid pulse. rdata carries the byte the memory presents at the end of the output-enable window. rdata holds that value until the next read completes.
- R8: mem_dq_oe is never 1 while mem_oe_n is 0, nor in the cycle right after mem_oe_n returns to 1.
- R9: Each access holds mem_ce_n low for at least ceil(T_AA_NS/CLK_PERIOD_NS) cycles (3 at defaults). Consecutive accesses are separated by at least one cycle with mem_ce_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a request |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address of the access |
| req_wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte returned by the last read |
| rvalid | output | 1 | One-cycle pulse when rdata is updated |
| mem_addr | output | 17 | Address pins of the memory |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven toward the data pads |
| mem_dq_in | input | 8 | Byte received from the data pads |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The risky coincidence is the end of a read meeting the start of a write. The read-data pulse and the release of the output enable fall in the same cycle. A write issued straight behind it could turn the pad driver on while the memory is still driving the bus. The bench provokes this by placing a write immediately after a read, both in the vector table and in a directed sequence. At every falling edge, a bus monitor judges that the drive enable stayed low while the output enable was low and for one cycle after, and the read data is compared against a shadow copy of memory contents. The memory model answers with a garbage byte until the address and output enable have been steady long enough, so an early capture shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } ctrl_state_e;

    // Pin levels presented to the memory for one cycle.
    typedef struct packed {
        logic ce_n;
        logic ce;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1,
                                        oe_n: 1'b1, dq_oe: 1'b0};

    // Whole clock cycles needed to cover a limit given in nanoseconds.
    function automatic int unsigned cycles_for(input int unsigned ns,
                                               input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Pin decode for each sequencer state.
    function automatic strobe_t strobes_of(input ctrl_state_e s);
        strobe_t p;
        p = STROBE_IDLE;
        case (s)
            ST_RD_SETUP: begin
                p.ce_n = 1'b0;
                p.ce   = 1'b1;
            end
            ST_RD_WAIT, ST_RD_CAPTURE: begin
                p.ce_n = 1'b0;
                p.ce   = 1'b1;
                p.oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_RECOVER: begin
                p.ce_n  = 1'b0;
                p.ce    = 1'b1;
                p.dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                p.ce_n  = 1'b0;
                p.ce    = 1'b1;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            default: p = STROBE_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned WR_PULSE_CYC = 3,
    parameter int unsigned WR_HOLD_CYC  = 1,
    parameter int unsigned RD_WAIT_CYC  = 4,
    parameter int unsigned TURN_CYC     = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    output logic        req_ready,
    output logic        accept,
    output ctrl_state_e state_q,
    output ctrl_state_e state_d
);
    localparam int unsigned MAX_CYC = max4(WR_PULSE_CYC, WR_HOLD_CYC, RD_WAIT_CYC, TURN_CYC);
    localparam int CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(WR_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(WR_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WAIT  = CNT_W'(RD_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CYC - 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LD_PULSE;
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            ST_RD_SETUP: begin
                state_d  = ST_RD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_WAIT;
            end
            ST_RD_WAIT: begin
                if (tmr_zero) state_d = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                state_d  = ST_TURNAROUND;
                tmr_load = 1'b1;
                tmr_val  = LD_TURN;
            end
            ST_TURNAROUND: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/sram_ctrl_phy.sv
module sram_ctrl_phy
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_state_e       state_q,
    input  ctrl_state_e       state_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output strobe_t           pins,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    // Pins are registered from the next state so they never glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            pins       <= STROBE_IDLE;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rdata      <= '0;
            rvalid     <= 1'b0;
        end else begin
            pins   <= strobes_of(state_d);
            rvalid <= (state_q == ST_RD_CAPTURE);
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            if (state_q == ST_RD_CAPTURE) rdata <= mem_dq_in;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          ADDR_W        = 17,
    parameter int          DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_WP_NS       = 45,
    parameter int unsigned T_AA_NS       = 55,
    parameter int unsigned WR_HOLD_CYC   = 1,
    parameter int unsigned TURN_CYC      = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned WR_PULSE_CYC = cycles_for(T_WP_NS, CLK_PERIOD_NS);
    // One extra cycle of margin on the access time.
    localparam int unsigned RD_WAIT_CYC  = cycles_for(T_AA_NS, CLK_PERIOD_NS) + 1;

    ctrl_state_e state_q, state_d;
    logic        accept;
    strobe_t     pins;

    sram_ctrl_fsm #(
        .WR_PULSE_CYC (WR_PULSE_CYC),
        .WR_HOLD_CYC  (WR_HOLD_CYC),
        .RD_WAIT_CYC  (RD_WAIT_CYC),
        .TURN_CYC     (TURN_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .state_q   (state_q),
        .state_d   (state_d)
    );

    sram_ctrl_phy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_phy (
        .clk        (clk),
        .rst        (rst),
        .state_q    (state_q),
        .state_d    (state_d),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .pins       (pins),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_ce    = pins.ce;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.dq_oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int          ADDR_W        = 17,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_WP_NS       = 45
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    localparam int unsigned WP = sram_ctrl_pkg::cycles_for(T_WP_NS, CLK_PERIOD_NS);

    // Length of the current write-strobe low run, saturating.
    logic [7:0] wl_q;
    always_ff @(posedge clk) begin
        if (rst)                   wl_q <= '0;
        else if (mem_we_n)         wl_q <= '0;
        else if (wl_q != 8'hFF)    wl_q <= wl_q + 1'b1;
    end

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_we_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n && mem_dq_oe));

    p_we_width_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we_n && wl_q != 8'd0) |-> (wl_q == 8'(WP)));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    p_oe_after_ce_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> (!$past(mem_ce_n) && mem_we_n));

    p_single_rvalid_r7: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    p_no_fight_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    p_turn_gap_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(mem_oe_n) |-> !mem_dq_oe);
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_WP_NS       (T_WP_NS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rvalid    (rvalid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
    localparam int WP     = 3;   // write strobe cycles at 20 ns
    localparam int OE_RUN = 5;   // output-enable low cycles per read
    localparam int CE_MIN = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rvalid;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sram_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [16:0] a);
        return a[7:0] ^ 8'h5A ^ {a[16:13], 4'h0};
    endfunction

    // ---------------- memory model and pin monitor ----------------
    logic [7:0]  mem [logic [16:0]];
    logic [7:0]  exp_mem [logic [16:0]];
    logic [16:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    logic        p_we_n = 1, p_oe_n = 1, p_ce_n = 1, p_dq_oe = 0, p_wr = 0;
    int          we_low = 0, oe_low = 0, ce_low = 0, addr_stable = 0;

    always_comb begin
        if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n && oe_low >= 2 && addr_stable >= 3)
            mem_dq_in = mem.exists(mem_addr) ? mem[mem_addr] : dflt(mem_addr);
        else
            mem_dq_in = 8'hEE;
    end

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit wr = !mem_ce_n && mem_ce && !mem_we_n;
            if (p_wr && !wr) mem[p_addr] = p_dq;
            // R5: address frozen while chip enable stays active
            if (!mem_ce_n && !p_ce_n && mem_addr != p_addr)
                chk(0, "R5 address moved under enable", mem_addr, p_addr);
            // R8: no drive while memory may still drive
            if (mem_dq_oe && (!mem_oe_n || !p_oe_n))
                chk(0, "R8 bus contention", mem_dq_oe, 0);
            // R3: write strobe width and companions
            if (!mem_we_n) begin
                we_low++;
                if (mem_ce_n || !mem_ce || !mem_oe_n)
                    chk(0, "R3 strobes during write", {mem_ce_n, mem_ce, mem_oe_n}, 3'b010);
            end else if (we_low != 0) begin
                chk(we_low == WP, "R3 write pulse width", we_low, WP);
                we_low = 0;
            end
            // R4: data setup and hold around the write strobe
            if (!mem_we_n && p_we_n)
                chk(p_dq_oe && mem_dq_oe, "R4 data driven before strobe", p_dq_oe, 1);
            if (!mem_we_n && !p_we_n && mem_dq_out != p_dq)
                chk(0, "R4 data changed during strobe", mem_dq_out, p_dq);
            if (mem_we_n && !p_we_n)
                chk(mem_dq_oe && mem_dq_out == p_dq, "R4 data hold after strobe",
                    mem_dq_out, p_dq);
            // R6: output enable window
            if (!mem_oe_n && p_oe_n)
                chk(!p_ce_n && mem_we_n, "R6 oe one cycle after ce", p_ce_n, 0);
            if (!mem_oe_n) oe_low++;
            else if (oe_low != 0) begin
                chk(oe_low == OE_RUN, "R6 oe low length", oe_low, OE_RUN);
                oe_low = 0;
            end
            // R9: minimum enable length
            if (!mem_ce_n) ce_low++;
            else if (ce_low != 0) begin
                chk(ce_low >= CE_MIN, "R9 ce low length", ce_low, CE_MIN);
                ce_low = 0;
            end
            addr_stable = (mem_addr == p_addr) ? addr_stable + 1 : 0;
            p_wr = wr; p_addr = mem_addr; p_dq = mem_dq_out; p_we_n = mem_we_n;
            p_oe_n = mem_oe_n; p_ce_n = mem_ce_n; p_dq_oe = mem_dq_oe;
        end
    end

    // ---------------- request tasks ----------------
    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        int n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R2 ready drops after accept", req_ready, 0);
    endtask

    function automatic logic [7:0] expect_at(input logic [16:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : dflt(a);
    endfunction

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        issue(1, a, d);
        exp_mem[a] = d;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_read(input logic [16:0] a);
        int n = 0;
        logic [7:0] e = expect_at(a);
        issue(0, a, 8'h00);
        while (!rvalid && n < 40) begin @(negedge clk); n++; end
        chk(rvalid == 1, "R7 rvalid pulse seen", rvalid, 1);
        chk(rdata == e, "R7 read data", rdata, e);
        @(negedge clk);
        chk(rvalid == 0, "R7 rvalid single cycle", rvalid, 0);
    endtask

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t [0:NV-1] VEC = '{
        '{1'b1, 17'h00000, 8'hA5},
        '{1'b1, 17'h1FFFF, 8'h3C},
        '{1'b0, 17'h00000, 8'h00},
        '{1'b0, 17'h1FFFF, 8'h00},
        '{1'b0, 17'h0ABCD, 8'h00},
        '{1'b1, 17'h0ABCD, 8'hFF},
        '{1'b1, 17'h0ABCE, 8'h00},
        '{1'b0, 17'h0ABCD, 8'h00},
        '{1'b1, 17'h00000, 8'h5A},
        '{1'b0, 17'h0ABCE, 8'h00},
        '{1'b0, 17'h00000, 8'h00},
        '{1'b1, 17'h10001, 8'h81}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle pins during reset
        chk({req_ready, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, rvalid} == 7'b1101100,
            "R1 reset state", {req_ready, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, rvalid},
            7'b1101100);
        rst = 0;
        @(negedge clk);
        chk({req_ready, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, rvalid} == 7'b1101100,
            "R1 state after reset", {req_ready, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, rvalid},
            7'b1101100);

        // Vector walk: writes, reads, read followed by write (R8 turnaround)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data);
            else           do_read(VEC[i].addr);
        end

        // R2: request raised while busy is ignored
        issue(1, 17'h00100, 8'h11);
        req_valid = 1; req_write = 1; req_addr = 17'h00101; req_wdata = 8'h99;
        @(negedge clk);
        chk(req_ready == 0, "R2 busy during write", req_ready, 0);
        req_valid = 0;
        while (!req_ready) @(negedge clk);
        exp_mem[17'h00100] = 8'h11;
        do_read(17'h00101);   // R2: must still hold its default pattern
        do_read(17'h00100);

        // R7: rdata holds across a following write
        do_read(17'h1FFFF);
        do_write(17'h00200, 8'h77);
        chk(rdata == expect_at(17'h1FFFF), "R7 rdata held", rdata, expect_at(17'h1FFFF));

        // R8: read immediately followed by write to the same address
        do_read(17'h00200);
        do_write(17'h00200, 8'h88);
        do_read(17'h00200);

        // R9: back-to-back reads keep a gap with enable high
        do_read(17'h0ABCD);
        do_read(17'h0ABCE);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule